// File: doc/BRIEF.md
# Fractional-Step Serial Clock Generator

This block derives a serial-bus clock from a fast reference clock by stepping a phase accumulator rather than counting down an integer divisor. Each of several stored profiles carries a 16-bit clock word (a frequency step plus two control bits) and a 3-bit signal word (edge choices and an input-path choice). A profile select input picks which profile drives the generator. An accumulator wrap toggles the internal clock phase. A global polarity input sets the level the serial clock rests at.

A chip-select gate input freezes the generator. While no target is selected, the serial clock sits at its idle level and the accumulator and phase are cleared. A transfer-start pulse can optionally re-zero the accumulator. Next to the clock, the block emits one-cycle strobes telling the shift logic where to drive out data and where to capture it. It also passes on a select bit for the input sampling path. There is no stream interface: every pin is a plain control or status level, and nothing is ever back-pressured.

Top module: `spiclk_gen`

## Requirements
- R1: While rst_n is low, sclk equals cpol, launch_stb and latch_stb are 0, and the accumulator and phase are 0.
- R2: The frequency field is bits [13:0] of the selected clock word. Values above 2048 act as 2048. On each gated-on cycle without restart, the accumulator (12 bits, initially 0) adds the effective step modulo 4096. Each wrap toggles the phase, so starting from zero a step of 1024 gives 4 toggles in 16 cycles and a step of 2048 gives 8.
- R3: Bit 14 of the clock word doubles the effective step. With bit 14 set and a frequency field of 2048 or more, the phase toggles on every gated-on cycle.
- R4: sclk equals phase XOR cpol at all times, so cpol is the idle level.
- R5: When bit 15 of the selected clock word is 1, a cycle with xfer_start=1 and cs_active=1 sets the accumulator to 0, with no step and no toggle in that cycle. When bit 15 is 0, xfer_start has no effect.
- R6: A cycle with cs_active=0 clears the accumulator and phase, and produces no strobe.
- R7: launch_stb is high for one cycle, coinciding with sclk's new level after a toggle, when the edge direction (rising means sclk goes to 1) matches bit 1 of the signal word (1 = rising, 0 = falling).
- R8: latch_stb behaves the same way, using bit 0 of the signal word. When both bits are equal, both strobes fire in the same cycle.
- R9: async_sel equals bit 2 of the selected signal word, combinationally.
- R10: Profile p occupies clk_cfg[16p+15:16p] and sig_cfg[3p+2:3p]. prof_sel picks the active profile, and a change takes effect on the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cfg | input | 16*NPROF | Clock words of all profiles |
| sig_cfg | input | 3*NPROF | Signal words of all profiles |
| prof_sel | input | PSEL_W | Active profile index |
| cpol | input | 1 | Idle level of sclk |
| cs_active | input | 1 | Gate: 1 while a target is selected |
| xfer_start | input | 1 | Pulse at the start of a transfer |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | Data-launch strobe |
| latch_stb | output | 1 | Data-capture strobe |
| async_sel | output | 1 | Input-path select for the capture logic |

## Verification
The sharpest collision is a transfer-start pulse landing in the very cycle the accumulator would wrap. With restart enabled the wrap must vanish, with no toggle and no strobe; with restart disabled the toggle must still occur. The random phase drives xfer_start at a low rate against varied steps and profiles, so such overlaps arise repeatedly, and a directed run sets up a known wrap cycle. Launch and latch strobes firing together, when both edge bits agree, are judged in the same cycle-by-cycle comparison against the bench's own model.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  localparam int unsigned CW_W  = 16;
  localparam int unsigned SIG_W = 3;
  localparam int unsigned FRQ_W = 14;

  typedef struct packed {
    logic             restart_en;
    logic             dbl_rate;
    logic [FRQ_W-1:0] freq;
  } clk_word_t;

  typedef struct packed {
    logic async_in;
    logic launch_rise;
    logic latch_rise;
  } sig_word_t;
endpackage

// File: rtl/spiclk_prof_mux.sv
module spiclk_prof_mux
  import spiclk_pkg::*;
#(
  parameter int NPROF  = 4,
  parameter int PSEL_W = 2
) (
  input  logic [CW_W*NPROF-1:0]  clk_cfg,
  input  logic [SIG_W*NPROF-1:0] sig_cfg,
  input  logic [PSEL_W-1:0]      prof_sel,
  output clk_word_t              cw_sel,
  output sig_word_t              sw_sel
);
  clk_word_t cw_arr [NPROF];
  sig_word_t sw_arr [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_unpack
    assign cw_arr[g] = clk_cfg[g*CW_W +: CW_W];
    assign sw_arr[g] = sig_cfg[g*SIG_W +: SIG_W];
  end

  assign cw_sel = cw_arr[prof_sel];
  assign sw_sel = sw_arr[prof_sel];
endmodule

// File: rtl/spiclk_phase_acc.sv
module spiclk_phase_acc
  import spiclk_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             xfer_start,
  input  clk_word_t        cw,
  output logic             phase_q,
  output logic             edge_due
);
  localparam logic [FRQ_W-1:0] FULL_F = FRQ_W'(1 << (ACC_W-1));
  localparam logic [ACC_W-1:0] FULL_A = ACC_W'(1 << (ACC_W-1));

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] f_eff;
  logic [ACC_W:0]   step;
  logic [ACC_W:0]   sum;
  logic             restart_hit;

  always_comb begin
    f_eff       = (cw.freq > FULL_F) ? FULL_A : cw.freq[ACC_W-1:0];
    step        = cw.dbl_rate ? {f_eff, 1'b0} : {1'b0, f_eff};
    sum         = {1'b0, acc_q} + step;
    restart_hit = xfer_start & cw.restart_en;
    edge_due    = gate & ~restart_hit & sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      phase_q <= 1'b0;
    end else if (!gate || restart_hit) begin
      acc_q   <= '0;
      if (!gate) phase_q <= 1'b0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      if (sum[ACC_W]) phase_q <= ~phase_q;
    end
  end

  AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (acc_q == '0 && !phase_q)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && xfer_start && cw.restart_en) |=> (acc_q == '0)); // R5
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !(xfer_start && cw.restart_en) && cw.dbl_rate && cw.freq >= FULL_F)
      |=> (phase_q != $past(phase_q))); // R3
endmodule

// File: rtl/spiclk_edge_strobe.sv
module spiclk_edge_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_due,
  input  logic phase_now,
  input  logic cpol,
  input  logic launch_rise,
  input  logic latch_rise,
  output logic launch_stb,
  output logic latch_stb
);
  logic goes_high;

  always_comb goes_high = ~phase_now ^ cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launch_stb <= 1'b0;
      latch_stb  <= 1'b0;
    end else begin
      launch_stb <= edge_due & (goes_high == launch_rise);
      latch_stb  <= edge_due & (goes_high == latch_rise);
    end
  end

  AST_STB_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_due |=> (!launch_stb && !latch_stb)); // R7
endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
  import spiclk_pkg::*;
#(
  parameter int NPROF  = 4,
  parameter int ACC_W  = 12,
  localparam int PSEL_W = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW_W*NPROF-1:0]  clk_cfg,
  input  logic [SIG_W*NPROF-1:0] sig_cfg,
  input  logic [PSEL_W-1:0]      prof_sel,
  input  logic                   cpol,
  input  logic                   cs_active,
  input  logic                   xfer_start,
  output logic                   sclk,
  output logic                   launch_stb,
  output logic                   latch_stb,
  output logic                   async_sel
);
  clk_word_t cw_sel;
  sig_word_t sw_sel;
  logic      phase_q;
  logic      edge_due;

  spiclk_prof_mux #(.NPROF(NPROF), .PSEL_W(PSEL_W)) u_mux (
    .clk_cfg  (clk_cfg),
    .sig_cfg  (sig_cfg),
    .prof_sel (prof_sel),
    .cw_sel   (cw_sel),
    .sw_sel   (sw_sel)
  );

  spiclk_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate       (cs_active),
    .xfer_start (xfer_start),
    .cw         (cw_sel),
    .phase_q    (phase_q),
    .edge_due   (edge_due)
  );

  spiclk_edge_strobe u_stb (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_due    (edge_due),
    .phase_now   (phase_q),
    .cpol        (cpol),
    .launch_rise (sw_sel.launch_rise),
    .latch_rise  (sw_sel.latch_rise),
    .launch_stb  (launch_stb),
    .latch_stb   (latch_stb)
  );

  assign sclk      = phase_q ^ cpol;
  assign async_sel = sw_sel.async_in;

  AST_STB_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb || latch_stb) |-> (phase_q != $past(phase_q))); // R8
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (sclk == cpol)); // R4
endmodule

// File: tb/sim_spiclk_gen.sv
`timescale 1ns/1ps
module sim_spiclk_gen;
  localparam int NPROF = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic [16*NPROF-1:0] clk_cfg;
  logic [3*NPROF-1:0]  sig_cfg;
  logic [1:0]          prof_sel;
  logic cpol, cs_active, xfer_start;
  logic sclk, launch_stb, latch_stb, async_sel;

  spiclk_gen #(.NPROF(NPROF), .ACC_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_cfg(clk_cfg), .sig_cfg(sig_cfg),
    .prof_sel(prof_sel), .cpol(cpol), .cs_active(cs_active),
    .xfer_start(xfer_start), .sclk(sclk), .launch_stb(launch_stb),
    .latch_stb(latch_stb), .async_sel(async_sel)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  int  m_acc    = 0;
  bit  m_ph     = 1'b0;
  bit  m_ls     = 1'b0;
  bit  m_cs     = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_step(logic [15:0] cw);
    int f = int'(cw[13:0]);
    if (f > 2048) f = 2048;
    return cw[14] ? 2*f : f;
  endfunction

  task automatic model_step();
    logic [15:0] cw = clk_cfg[prof_sel*16 +: 16];
    logic [2:0]  sw = sig_cfg[prof_sel*3 +: 3];
    m_ls = 1'b0; m_cs = 1'b0;
    if (!cs_active) begin
      m_acc = 0; m_ph = 1'b0;
    end else if (xfer_start && cw[15]) begin
      m_acc = 0;
    end else begin
      int s = m_acc + eff_step(cw);
      m_acc = s % 4096;
      if (s >= 4096) begin
        bit up;
        m_ph = ~m_ph;
        up   = m_ph ^ cpol;
        m_ls = (up == sw[1]);
        m_cs = (up == sw[0]);
      end
    end
  endtask

  task automatic check_all(string tag);
    logic [2:0] sw = sig_cfg[prof_sel*3 +: 3];
    chk({tag, " R4 sclk"},       32'(sclk),       32'(m_ph ^ cpol));
    chk({tag, " R7 launch_stb"}, 32'(launch_stb), 32'(m_ls));
    chk({tag, " R8 latch_stb"},  32'(latch_stb),  32'(m_cs));
    chk({tag, " R9 async_sel"},  32'(async_sel),  32'(sw[2]));
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic count_toggles(string tag, int ncyc, int exp);
    int  tg = 0;
    logic prev;
    cs_active = 1'b0;
    cyc(tag);
    cs_active = 1'b1;
    prev = sclk;
    for (int i = 0; i < ncyc; i++) begin
      cyc(tag);
      if (sclk != prev) tg++;
      prev = sclk;
    end
    chk({tag, " toggle count"}, 32'(tg), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C10C));
    rst_n = 1'b0; clk_cfg = '0; sig_cfg = '0; prof_sel = '0;
    cpol = 1'b1; cs_active = 1'b1; xfer_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset sclk idle",  32'(sclk),       32'(1));
    chk("R1 reset launch_stb", 32'(launch_stb), 32'(0));
    chk("R1 reset latch_stb",  32'(latch_stb),  32'(0));
    cpol = 1'b0;
    rst_n = 1'b1;

    // R2: plain step and clamp
    clk_cfg[15:0] = 16'h0400; sig_cfg[2:0] = 3'b010;
    count_toggles("R2 step1024", 16, 4);
    clk_cfg[15:0] = 16'h3FFF;
    count_toggles("R2 clamp", 16, 8);

    // R3: doubled step at full field
    clk_cfg[15:0] = 16'h4800; sig_cfg[2:0] = 3'b111;
    count_toggles("R3 double", 16, 16);

    // R5: restart hits the cycle that would wrap (1536 step: wrap on 3rd)
    clk_cfg[15:0] = 16'h8600; sig_cfg[2:0] = 3'b001;
    count_toggles("R5 warmup", 2, 0);
    xfer_start = 1'b1;
    cyc("R5 restart at wrap");
    chk("R5 no edge at restart", 32'(launch_stb | latch_stb), 32'(0));
    xfer_start = 1'b0;
    repeat (6) cyc("R5 after restart");
    clk_cfg[15:0] = 16'h0600;
    count_toggles("R5 no-restart warmup", 2, 0);
    xfer_start = 1'b1;
    cyc("R5 start ignored");
    chk("R5 wrap kept", 32'(launch_stb | latch_stb), 32'(1));
    xfer_start = 1'b0;

    // R6: gate low with polarity flips
    cs_active = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cpol = i[0];
      cyc("R6 gated");
      chk("R6 idle level", 32'(sclk), 32'(cpol));
    end
    cs_active = 1'b1; cpol = 1'b0;

    // R10 + random mix
    for (int p = 0; p < NPROF; p++) begin
      clk_cfg[p*16 +: 16] = 16'($urandom);
      sig_cfg[p*3 +: 3]   = 3'($urandom);
    end
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 99) < 4)  prof_sel = 2'($urandom);
      if ($urandom_range(0, 99) < 2)  cpol = ~cpol;
      cs_active  = ($urandom_range(0, 99) < 93);
      xfer_start = ($urandom_range(0, 99) < 6);
      if ($urandom_range(0, 199) == 0) begin
        int p = $urandom_range(0, NPROF-1);
        clk_cfg[p*16 +: 16] = 16'($urandom);
        sig_cfg[p*3 +: 3]   = 3'($urandom);
      end
      cyc("R10 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule